// File: doc/BRIEF.md
# Coherence message event classifier

This block sits in front of the protocol state machine of a shared cache bank. Three message sources feed it: unblock notices, responses (either from a private first-level cache or from off-chip memory), and requests from the private caches. In each cycle it selects one valid message by fixed priority and turns that message into a single protocol event code and the line address that the event applies to. The result is registered, so the event appears one clock after the message is presented.

Decoding depends on line context. It does not depend on the message type alone. An upgrade from a cache that is not a recorded sharer becomes a full write request. A writeback from a non-sharer is marked stale. A request that misses with no free way is not decoded at all: a replacement event for the victim line is raised instead. A private-cache ack is checked against the outstanding ack count to tell the final ack from an intermediate one. A message whose type is not defined for its source raises an error flag and produces no event.

Top module: `coh_evt_classifier`

## Requirements
- R1: After reset, and one cycle after any cycle with no valid input, evt_valid, evt_err and evt_src are all 0. The outputs are registered: a message presented before clock edge k is reflected after edge k.
- R2: Priority is unblock over response over request. evt_src reports the source of the selected message: 1 = unblock, 2 = response, 3 = request, 0 = none. A lower-priority message that is valid in the same cycle has no effect on the outputs.
- R3: A request type GETS (0), instruction fetch (1) or GETX (2) yields event 0, 1 or 2 respectively, at the request address.
- R4: A request of type upgrade (3) yields event 3 only when req_tag_hit is 1 and req_sharers[req_id] is 1. Otherwise it yields event 2 (write).
- R5: A request of type writeback (4) yields event 4 when req_tag_hit is 1 and req_sharers[req_id] is 1. Otherwise it yields event 5 (stale writeback).
- R6: When req_tag_hit is 0 and req_way_free is 0, the request type is not decoded. The event is 6 (dirty replacement) if victim_dirty is 1, else 7 (clean replacement), and evt_addr is victim_addr.
- R7: A response with rsp_from_l1=1 and type data (0) yields event 8 when rsp_dirty is 1 and event 9 when it is 0.
- R8: A response with rsp_from_l1=1 and type ack (1) yields event 11 (final ack) when rsp_pend_acks minus rsp_ack_cnt, modulo 2^ACK_W, is zero. Otherwise it yields event 10.
- R9: A response with rsp_from_l1=0 and type memory data (2), memory ack (3) or invalidate (4) yields event 12, 13 or 14 respectively, at rsp_addr.
- R10: An unblock of type 0 yields event 15. An unblock of type 1 yields event 16 (exclusive unblock). In both cases the event is at ubk_addr.
- R11: A selected message whose type is undefined for its source raises evt_err with evt_valid=0, and evt_src shows the source. Undefined types are: request types 5–7 when R6 does not apply, response types 2–7 from a private cache, response types 0, 1, 5–7 from memory, and unblock types 2–3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ubk_valid | input | 1 | Unblock message present |
| ubk_type | input | 2 | Unblock type |
| ubk_addr | input | ADDR_W | Unblock line address |
| rsp_valid | input | 1 | Response message present |
| rsp_from_l1 | input | 1 | 1 = sender is a private cache, 0 = off-chip |
| rsp_type | input | 3 | Response type |
| rsp_dirty | input | 1 | Dirty flag carried with data |
| rsp_ack_cnt | input | ACK_W | Ack count carried by the message |
| rsp_pend_acks | input | ACK_W | Outstanding ack count for the line |
| rsp_addr | input | ADDR_W | Response line address |
| req_valid | input | 1 | Request message present |
| req_type | input | 3 | Request type |
| req_id | input | ID_W | Requesting private cache index |
| req_addr | input | ADDR_W | Request line address |
| req_tag_hit | input | 1 | Line tag present in the bank |
| req_way_free | input | 1 | A free way exists in the line's set |
| req_sharers | input | NUM_L1 | Sharer bitmap of the line |
| victim_addr | input | ADDR_W | Address of the replacement victim |
| victim_dirty | input | 1 | Victim line is dirty |
| evt_valid | output | 1 | An event is reported |
| evt_code | output | 5 | Event code |
| evt_src | output | 2 | Source of the selected message |
| evt_addr | output | ADDR_W | Address the event applies to |
| evt_err | output | 1 | Selected message had an undefined type |

## Verification
Requests are applied with every combination of tag hit, free way and sharer bit that matters. Each combination separates a direct decode, an upgrade demoted to a write, a stale writeback, and a replacement that redirects the address to the victim. The replacement is applied with an undefined type to show that type decode is skipped. Ack responses use equal counts, a count that leaves work outstanding, zero against zero, and a wrapping difference, so that an exact-zero test is told apart from a less-or-equal test. Simultaneous valid messages, one of them carrying an undefined type, show that the priority selects before decode and that a losing message leaves no trace.

// File: rtl/coh_evt_pkg.sv
package coh_evt_pkg;

  typedef enum logic [4:0] {
    EV_GETS       = 5'd0,
    EV_GET_INSTR  = 5'd1,
    EV_GETX       = 5'd2,
    EV_UPGRADE    = 5'd3,
    EV_WB         = 5'd4,
    EV_WB_STALE   = 5'd5,
    EV_REPL_DIRTY = 5'd6,
    EV_REPL_CLEAN = 5'd7,
    EV_DATA_DIRTY = 5'd8,
    EV_DATA_CLEAN = 5'd9,
    EV_ACK        = 5'd10,
    EV_ACK_LAST   = 5'd11,
    EV_MEM_DATA   = 5'd12,
    EV_MEM_ACK    = 5'd13,
    EV_EXT_INV    = 5'd14,
    EV_UNBLOCK    = 5'd15,
    EV_UNBLOCK_EX = 5'd16
  } evt_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_UBK  = 2'd1,
    SRC_RSP  = 2'd2,
    SRC_REQ  = 2'd3
  } src_e;

  localparam logic [2:0] RQ_GETS   = 3'd0;
  localparam logic [2:0] RQ_GETI   = 3'd1;
  localparam logic [2:0] RQ_GETX   = 3'd2;
  localparam logic [2:0] RQ_UPG    = 3'd3;
  localparam logic [2:0] RQ_WB     = 3'd4;

  localparam logic [2:0] RS_DATA   = 3'd0;
  localparam logic [2:0] RS_ACK    = 3'd1;
  localparam logic [2:0] RS_MDATA  = 3'd2;
  localparam logic [2:0] RS_MACK   = 3'd3;
  localparam logic [2:0] RS_INV    = 3'd4;

  localparam logic [1:0] UB_PLAIN  = 2'd0;
  localparam logic [1:0] UB_EXCL   = 2'd1;

  typedef struct packed {
    logic ok;
    logic err;
    evt_e code;
  } dec_t;

endpackage

// File: rtl/coh_ubk_decode.sv
module coh_ubk_decode
  import coh_evt_pkg::*;
(
  input  logic [1:0] ubk_type,
  output dec_t       dec
);
  always_comb begin
    dec = '{ok: 1'b0, err: 1'b0, code: EV_UNBLOCK};
    unique case (ubk_type)
      UB_PLAIN: begin dec.ok = 1'b1; dec.code = EV_UNBLOCK;    end
      UB_EXCL:  begin dec.ok = 1'b1; dec.code = EV_UNBLOCK_EX; end
      default:  dec.err = 1'b1;
    endcase
  end
endmodule

// File: rtl/coh_rsp_decode.sv
module coh_rsp_decode
  import coh_evt_pkg::*;
#(
  parameter int ACK_W = 8
) (
  input  logic             from_l1,
  input  logic [2:0]       rsp_type,
  input  logic             dirty,
  input  logic [ACK_W-1:0] ack_cnt,
  input  logic [ACK_W-1:0] pend_acks,
  output dec_t             dec
);
  logic [ACK_W-1:0] remain;
  logic             last_ack;

  assign remain   = pend_acks - ack_cnt;
  assign last_ack = (remain == '0);

  always_comb begin
    dec = '{ok: 1'b0, err: 1'b0, code: EV_ACK};
    if (from_l1) begin
      case (rsp_type)
        RS_DATA: begin
          dec.ok   = 1'b1;
          dec.code = dirty ? EV_DATA_DIRTY : EV_DATA_CLEAN;
        end
        RS_ACK: begin
          dec.ok   = 1'b1;
          dec.code = last_ack ? EV_ACK_LAST : EV_ACK;
        end
        default: dec.err = 1'b1;
      endcase
    end else begin
      case (rsp_type)
        RS_MDATA: begin dec.ok = 1'b1; dec.code = EV_MEM_DATA; end
        RS_MACK:  begin dec.ok = 1'b1; dec.code = EV_MEM_ACK;  end
        RS_INV:   begin dec.ok = 1'b1; dec.code = EV_EXT_INV;  end
        default:  dec.err = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/coh_req_decode.sv
module coh_req_decode
  import coh_evt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NUM_L1 = 8,
  parameter int ID_W   = 3
) (
  input  logic [2:0]        req_type,
  input  logic [ID_W-1:0]   req_id,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              tag_hit,
  input  logic              way_free,
  input  logic [NUM_L1-1:0] sharers,
  input  logic [ADDR_W-1:0] victim_addr,
  input  logic              victim_dirty,
  output dec_t              dec,
  output logic [ADDR_W-1:0] dec_addr
);
  logic [NUM_L1-1:0] id_hit;
  logic              is_sharer;
  logic              need_repl;

  for (genvar g = 0; g < NUM_L1; g++) begin : g_member
    assign id_hit[g] = sharers[g] && (req_id == ID_W'(g));
  end

  assign is_sharer = tag_hit && (|id_hit);
  assign need_repl = !tag_hit && !way_free;

  always_comb begin
    dec      = '{ok: 1'b0, err: 1'b0, code: EV_GETS};
    dec_addr = req_addr;
    if (need_repl) begin
      dec.ok   = 1'b1;
      dec.code = victim_dirty ? EV_REPL_DIRTY : EV_REPL_CLEAN;
      dec_addr = victim_addr;
    end else begin
      case (req_type)
        RQ_GETS: begin dec.ok = 1'b1; dec.code = EV_GETS;      end
        RQ_GETI: begin dec.ok = 1'b1; dec.code = EV_GET_INSTR; end
        RQ_GETX: begin dec.ok = 1'b1; dec.code = EV_GETX;      end
        RQ_UPG: begin
          dec.ok   = 1'b1;
          dec.code = is_sharer ? EV_UPGRADE : EV_GETX;
        end
        RQ_WB: begin
          dec.ok   = 1'b1;
          dec.code = is_sharer ? EV_WB : EV_WB_STALE;
        end
        default: dec.err = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/coh_evt_classifier.sv
module coh_evt_classifier
  import coh_evt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NUM_L1 = 8,
  parameter int ACK_W  = 8,
  localparam int ID_W  = (NUM_L1 > 1) ? $clog2(NUM_L1) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ubk_valid,
  input  logic [1:0]        ubk_type,
  input  logic [ADDR_W-1:0] ubk_addr,
  input  logic              rsp_valid,
  input  logic              rsp_from_l1,
  input  logic [2:0]        rsp_type,
  input  logic              rsp_dirty,
  input  logic [ACK_W-1:0]  rsp_ack_cnt,
  input  logic [ACK_W-1:0]  rsp_pend_acks,
  input  logic [ADDR_W-1:0] rsp_addr,
  input  logic              req_valid,
  input  logic [2:0]        req_type,
  input  logic [ID_W-1:0]   req_id,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_tag_hit,
  input  logic              req_way_free,
  input  logic [NUM_L1-1:0] req_sharers,
  input  logic [ADDR_W-1:0] victim_addr,
  input  logic              victim_dirty,
  output logic              evt_valid,
  output logic [4:0]        evt_code,
  output logic [1:0]        evt_src,
  output logic [ADDR_W-1:0] evt_addr,
  output logic              evt_err
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  dec_t              ubk_dec, rsp_dec, req_dec;
  logic [ADDR_W-1:0] req_dec_addr;

  coh_ubk_decode u_ubk (
    .ubk_type (ubk_type),
    .dec      (ubk_dec)
  );

  coh_rsp_decode #(.ACK_W(ACK_W)) u_rsp (
    .from_l1   (rsp_from_l1),
    .rsp_type  (rsp_type),
    .dirty     (rsp_dirty),
    .ack_cnt   (rsp_ack_cnt),
    .pend_acks (rsp_pend_acks),
    .dec       (rsp_dec)
  );

  coh_req_decode #(.ADDR_W(ADDR_W), .NUM_L1(NUM_L1), .ID_W(ID_W)) u_req (
    .req_type     (req_type),
    .req_id       (req_id),
    .req_addr     (req_addr),
    .tag_hit      (req_tag_hit),
    .way_free     (req_way_free),
    .sharers      (req_sharers),
    .victim_addr  (victim_addr),
    .victim_dirty (victim_dirty),
    .dec          (req_dec),
    .dec_addr     (req_dec_addr)
  );

  // fixed-priority select and next state
  logic              valid_d, err_d;
  evt_e              code_d;
  src_e              src_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    valid_d = 1'b0;
    err_d   = 1'b0;
    code_d  = EV_GETS;
    src_d   = SRC_NONE;
    addr_d  = '0;
    if (ubk_valid) begin
      valid_d = ubk_dec.ok;
      err_d   = ubk_dec.err;
      code_d  = ubk_dec.code;
      src_d   = SRC_UBK;
      addr_d  = ubk_addr;
    end else if (rsp_valid) begin
      valid_d = rsp_dec.ok;
      err_d   = rsp_dec.err;
      code_d  = rsp_dec.code;
      src_d   = SRC_RSP;
      addr_d  = rsp_addr;
    end else if (req_valid) begin
      valid_d = req_dec.ok;
      err_d   = req_dec.err;
      code_d  = req_dec.code;
      src_d   = SRC_REQ;
      addr_d  = req_dec_addr;
    end
  end

  logic              valid_q, err_q;
  logic [4:0]        code_q;
  logic [1:0]        src_q;
  logic [ADDR_W-1:0] addr_q;
  logic              upd_en;

  assign upd_en = ubk_valid | rsp_valid | req_valid | valid_q | err_q;

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      code_q  <= '0;
      src_q   <= '0;
      addr_q  <= '0;
    end else if (upd_en) begin
      valid_q <= valid_d;
      err_q   <= err_d;
      code_q  <= code_d;
      src_q   <= src_d;
      addr_q  <= addr_d;
    end
  end

  assign evt_valid = valid_q;
  assign evt_err   = err_q;
  assign evt_code  = code_q;
  assign evt_src   = src_q;
  assign evt_addr  = addr_q;

endmodule

// File: rtl/coh_evt_checker.sv
module coh_evt_checker #(
  parameter int ADDR_W = 32,
  parameter int ACK_W  = 8
) (
  input logic              clk,
  input logic              rst_live,
  input logic              ubk_valid,
  input logic              rsp_valid,
  input logic              req_valid,
  input logic              req_tag_hit,
  input logic [ACK_W-1:0]  rsp_ack_cnt,
  input logic [ACK_W-1:0]  rsp_pend_acks,
  input logic [ADDR_W-1:0] victim_addr,
  input logic              evt_valid,
  input logic [4:0]        evt_code,
  input logic [1:0]        evt_src,
  input logic [ADDR_W-1:0] evt_addr,
  input logic              evt_err
);
  logic armed_q;
  always_ff @(posedge clk or negedge rst_live) begin
    if (!rst_live) armed_q <= 1'b0;
    else           armed_q <= 1'b1;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_live)
    armed_q && $past(!ubk_valid && !rsp_valid && !req_valid) |-> !evt_valid && !evt_err && evt_src == 2'd0);

  assert_ubk_first_R2: assert property (@(posedge clk) disable iff (!rst_live)
    armed_q && $past(ubk_valid) |-> evt_src == 2'd1 && (evt_valid || evt_err));

  assert_rsp_over_req_R2: assert property (@(posedge clk) disable iff (!rst_live)
    armed_q && $past(rsp_valid && !ubk_valid) |-> evt_src == 2'd2);

  assert_upgrade_hit_R4: assert property (@(posedge clk) disable iff (!rst_live)
    armed_q && evt_valid && evt_code == 5'd3 |-> $past(req_tag_hit));

  assert_repl_victim_R6: assert property (@(posedge clk) disable iff (!rst_live)
    armed_q && evt_valid && (evt_code == 5'd6 || evt_code == 5'd7) |-> evt_addr == $past(victim_addr));

  assert_last_ack_R8: assert property (@(posedge clk) disable iff (!rst_live)
    armed_q && evt_valid && evt_code == 5'd11 |-> $past(rsp_pend_acks) == $past(rsp_ack_cnt));

  assert_err_excl_R11: assert property (@(posedge clk) disable iff (!rst_live)
    !(evt_valid && evt_err));
endmodule

bind coh_evt_classifier coh_evt_checker #(.ADDR_W(ADDR_W), .ACK_W(ACK_W)) u_chk (
  .clk           (clk),
  .rst_live      (rst_sync_q),
  .ubk_valid     (ubk_valid),
  .rsp_valid     (rsp_valid),
  .req_valid     (req_valid),
  .req_tag_hit   (req_tag_hit),
  .rsp_ack_cnt   (rsp_ack_cnt),
  .rsp_pend_acks (rsp_pend_acks),
  .victim_addr   (victim_addr),
  .evt_valid     (evt_valid),
  .evt_code      (evt_code),
  .evt_src       (evt_src),
  .evt_addr      (evt_addr),
  .evt_err       (evt_err)
);

// File: tb/coh_evt_classifier_bench.sv
module coh_evt_classifier_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int NUM_L1 = 8;
  localparam int ACK_W  = 8;
  localparam int ID_W   = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ubk_valid;
  logic [1:0]        ubk_type;
  logic [ADDR_W-1:0] ubk_addr;
  logic              rsp_valid, rsp_from_l1, rsp_dirty;
  logic [2:0]        rsp_type;
  logic [ACK_W-1:0]  rsp_ack_cnt, rsp_pend_acks;
  logic [ADDR_W-1:0] rsp_addr;
  logic              req_valid, req_tag_hit, req_way_free, victim_dirty;
  logic [2:0]        req_type;
  logic [ID_W-1:0]   req_id;
  logic [ADDR_W-1:0] req_addr, victim_addr;
  logic [NUM_L1-1:0] req_sharers;
  logic              evt_valid, evt_err;
  logic [4:0]        evt_code;
  logic [1:0]        evt_src;
  logic [ADDR_W-1:0] evt_addr;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coh_evt_classifier #(.ADDR_W(ADDR_W), .NUM_L1(NUM_L1), .ACK_W(ACK_W)) u_coh_evt_classifier (
    .clk(clk), .rst_n(rst_n),
    .ubk_valid(ubk_valid), .ubk_type(ubk_type), .ubk_addr(ubk_addr),
    .rsp_valid(rsp_valid), .rsp_from_l1(rsp_from_l1), .rsp_type(rsp_type),
    .rsp_dirty(rsp_dirty), .rsp_ack_cnt(rsp_ack_cnt), .rsp_pend_acks(rsp_pend_acks),
    .rsp_addr(rsp_addr),
    .req_valid(req_valid), .req_type(req_type), .req_id(req_id), .req_addr(req_addr),
    .req_tag_hit(req_tag_hit), .req_way_free(req_way_free), .req_sharers(req_sharers),
    .victim_addr(victim_addr), .victim_dirty(victim_dirty),
    .evt_valid(evt_valid), .evt_code(evt_code), .evt_src(evt_src),
    .evt_addr(evt_addr), .evt_err(evt_err)
  );

  task automatic idle();
    ubk_valid = 0; ubk_type = 0; ubk_addr = '0;
    rsp_valid = 0; rsp_from_l1 = 0; rsp_type = 0; rsp_dirty = 0;
    rsp_ack_cnt = 0; rsp_pend_acks = 0; rsp_addr = '0;
    req_valid = 0; req_type = 0; req_id = 0; req_addr = '0;
    req_tag_hit = 1; req_way_free = 1; req_sharers = '0;
    victim_addr = '0; victim_dirty = 0;
  endtask

  // expects: valid, err, src, code, addr (code/addr compared only when valid)
  task automatic expect_out(string req, bit v, bit e, logic [1:0] s,
                            logic [4:0] c, logic [ADDR_W-1:0] a);
    total++;
    if (evt_valid !== v || evt_err !== e || evt_src !== s ||
        (v && (evt_code !== c || evt_addr !== a))) begin
      bad++;
      $display("FAIL %s: got v=%0b e=%0b src=%0d code=%0d addr=%h exp v=%0b e=%0b src=%0d code=%0d addr=%h",
               req, evt_valid, evt_err, evt_src, evt_code, evt_addr, v, e, s, c, a);
    end
  endtask

  // inputs set up by caller after this negedge; wait one edge, sample, clear
  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    expect_out("R1 reset", 0, 0, 2'd0, 5'd0, '0);
  endtask

  task automatic t_plain_requests();
    for (int t = 0; t < 3; t++) begin
      idle(); req_valid = 1; req_type = 3'(t); req_addr = 32'h1000 + 32'(t);
      step(); expect_out("R3 plain request", 1, 0, 2'd3, 5'(t), 32'h1000 + 32'(t));
    end
    idle(); step(); expect_out("R1 idle after traffic", 0, 0, 2'd0, 5'd0, '0);
  endtask

  task automatic t_upgrade();
    idle(); req_valid = 1; req_type = 3'd3; req_id = 3'd5; req_sharers = 8'b0010_0000;
    req_addr = 32'h2000; step(); expect_out("R4 upgrade sharer", 1, 0, 2'd3, 5'd3, 32'h2000);
    idle(); req_valid = 1; req_type = 3'd3; req_id = 3'd5; req_sharers = 8'b1101_1111;
    req_addr = 32'h2004; step(); expect_out("R4 upgrade non-sharer", 1, 0, 2'd3, 5'd2, 32'h2004);
    idle(); req_valid = 1; req_type = 3'd3; req_id = 3'd5; req_sharers = 8'b0010_0000;
    req_tag_hit = 0; req_way_free = 1; req_addr = 32'h2008;
    step(); expect_out("R4 upgrade tag miss", 1, 0, 2'd3, 5'd2, 32'h2008);
  endtask

  task automatic t_writeback();
    idle(); req_valid = 1; req_type = 3'd4; req_id = 3'd0; req_sharers = 8'b0000_0001;
    req_addr = 32'h3000; step(); expect_out("R5 writeback sharer", 1, 0, 2'd3, 5'd4, 32'h3000);
    idle(); req_valid = 1; req_type = 3'd4; req_id = 3'd7; req_sharers = 8'b0000_0001;
    req_addr = 32'h3004; step(); expect_out("R5 writeback stale", 1, 0, 2'd3, 5'd5, 32'h3004);
  endtask

  task automatic t_replacement();
    idle(); req_valid = 1; req_type = 3'd2; req_tag_hit = 0; req_way_free = 0;
    req_addr = 32'h4000; victim_addr = 32'hBEEF_0040; victim_dirty = 1;
    step(); expect_out("R6 dirty replacement", 1, 0, 2'd3, 5'd6, 32'hBEEF_0040);
    idle(); req_valid = 1; req_type = 3'd7; req_tag_hit = 0; req_way_free = 0;
    req_addr = 32'h4004; victim_addr = 32'hCAFE_0080; victim_dirty = 0;
    step(); expect_out("R6 clean replacement skips decode", 1, 0, 2'd3, 5'd7, 32'hCAFE_0080);
  endtask

  task automatic t_l1_responses();
    idle(); rsp_valid = 1; rsp_from_l1 = 1; rsp_type = 3'd0; rsp_dirty = 1; rsp_addr = 32'h5000;
    step(); expect_out("R7 dirty data", 1, 0, 2'd2, 5'd8, 32'h5000);
    idle(); rsp_valid = 1; rsp_from_l1 = 1; rsp_type = 3'd0; rsp_dirty = 0; rsp_addr = 32'h5004;
    step(); expect_out("R7 clean data", 1, 0, 2'd2, 5'd9, 32'h5004);
    idle(); rsp_valid = 1; rsp_from_l1 = 1; rsp_type = 3'd1; rsp_pend_acks = 3; rsp_ack_cnt = 3;
    rsp_addr = 32'h5008; step(); expect_out("R8 final ack", 1, 0, 2'd2, 5'd11, 32'h5008);
    idle(); rsp_valid = 1; rsp_from_l1 = 1; rsp_type = 3'd1; rsp_pend_acks = 3; rsp_ack_cnt = 1;
    rsp_addr = 32'h500C; step(); expect_out("R8 partial ack", 1, 0, 2'd2, 5'd10, 32'h500C);
    idle(); rsp_valid = 1; rsp_from_l1 = 1; rsp_type = 3'd1; rsp_pend_acks = 0; rsp_ack_cnt = 0;
    rsp_addr = 32'h5010; step(); expect_out("R8 zero ack", 1, 0, 2'd2, 5'd11, 32'h5010);
    idle(); rsp_valid = 1; rsp_from_l1 = 1; rsp_type = 3'd1; rsp_pend_acks = 1; rsp_ack_cnt = 2;
    rsp_addr = 32'h5014; step(); expect_out("R8 wrapping ack", 1, 0, 2'd2, 5'd10, 32'h5014);
  endtask

  task automatic t_mem_responses();
    for (int t = 2; t < 5; t++) begin
      idle(); rsp_valid = 1; rsp_from_l1 = 0; rsp_type = 3'(t); rsp_addr = 32'h6000 + 32'(t);
      step(); expect_out("R9 memory response", 1, 0, 2'd2, 5'(10 + t), 32'h6000 + 32'(t));
    end
  endtask

  task automatic t_unblock();
    idle(); ubk_valid = 1; ubk_type = 2'd0; ubk_addr = 32'h7000;
    step(); expect_out("R10 unblock", 1, 0, 2'd1, 5'd15, 32'h7000);
    idle(); ubk_valid = 1; ubk_type = 2'd1; ubk_addr = 32'h7004;
    step(); expect_out("R10 exclusive unblock", 1, 0, 2'd1, 5'd16, 32'h7004);
  endtask

  task automatic t_errors();
    idle(); req_valid = 1; req_type = 3'd6; step(); expect_out("R11 bad request", 0, 1, 2'd3, 5'd0, '0);
    idle(); rsp_valid = 1; rsp_from_l1 = 1; rsp_type = 3'd2;
    step(); expect_out("R11 memory type from private cache", 0, 1, 2'd2, 5'd0, '0);
    idle(); rsp_valid = 1; rsp_from_l1 = 0; rsp_type = 3'd1;
    step(); expect_out("R11 ack type from memory", 0, 1, 2'd2, 5'd0, '0);
    idle(); ubk_valid = 1; ubk_type = 2'd3; step(); expect_out("R11 bad unblock", 0, 1, 2'd1, 5'd0, '0);
  endtask

  task automatic t_priority();
    idle(); ubk_valid = 1; ubk_type = 2'd1; ubk_addr = 32'h8000;
    rsp_valid = 1; rsp_from_l1 = 0; rsp_type = 3'd2; rsp_addr = 32'h8004;
    req_valid = 1; req_type = 3'd0; req_addr = 32'h8008;
    step(); expect_out("R2 unblock wins", 1, 0, 2'd1, 5'd16, 32'h8000);
    idle(); rsp_valid = 1; rsp_from_l1 = 0; rsp_type = 3'd4; rsp_addr = 32'h8010;
    req_valid = 1; req_type = 3'd2; req_addr = 32'h8014;
    step(); expect_out("R2 response over request", 1, 0, 2'd2, 5'd14, 32'h8010);
    idle(); ubk_valid = 1; ubk_type = 2'd2;
    rsp_valid = 1; rsp_from_l1 = 1; rsp_type = 3'd0; rsp_addr = 32'h8020;
    step(); expect_out("R2 bad unblock still wins", 0, 1, 2'd1, 5'd0, '0);
    idle(); step(); expect_out("R1 idle clears error", 0, 0, 2'd0, 5'd0, '0);
  endtask

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_plain_requests();
    t_upgrade();
    t_writeback();
    t_replacement();
    t_l1_responses();
    t_mem_responses();
    t_unblock();
    t_errors();
    t_priority();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: got running exp finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule